// File: doc/BRIEF.md
# Client Transmit Acceptor with Inter-Frame Gap Hold-Off

This block sits on the MAC side of an 8-bit client transmit interface. The client offers a frame one byte per cycle, qualified by a data-valid strobe. The first byte of each frame stays on the data bus until the block acknowledges it. The block withholds that acknowledge until the inter-frame gap after the previous frame has passed and no pause request is active. Once acknowledged, the frame streams in at one byte per cycle until valid falls, which marks the end of the frame.

The accepted bytes leave the block as a registered byte stream. Start and end markers sit on the first and last bytes, and an error flag is raised when the client signals an underrun at the point where valid drops. Back-to-back frames work as follows: the client lowers valid for exactly one cycle and then raises it again with the first byte of the next frame. That byte then waits on the bus until the gap allows an acknowledge.

Top module: `tx_client_acceptor`

## Requirements
- R1: After reset, `cl_ack`, `tx_valid`, `tx_sof`, `tx_eof` and `tx_err` are low. The first frame after reset is acknowledged in the same cycle `cl_valid` first rises, because no gap is owed yet.
- R2: `cl_ack` is high in exactly one cycle per frame. That cycle is the first cycle in which `cl_valid` is high, the gap has elapsed and `pause_req` is low. It is combinational from those inputs.
- R3: While `pause_req` is high, `cl_ack` stays low. A frame that has already been acknowledged keeps streaming even if `pause_req` rises during it.
- R4: While `cl_valid` is high without an acknowledge, no byte is taken. The byte present in the acknowledge cycle is the first byte output, and no output beat appears during the hold.
- R5: A byte accepted in cycle k (the acknowledge cycle, or any later cycle of the frame with `cl_valid` high) appears on `tx_data` with `tx_valid` high in cycle k+2.
- R6: `tx_sof` is high on the first output byte of a frame. `tx_eof` is high on the byte accepted in the cycle just before `cl_valid` fell. A one-byte frame carries both markers on its single beat. Between the markers, `tx_valid` stays high on consecutive cycles.
- R7: With IPG = 12 (parameter, default), at least IPG cycles with `tx_valid` low separate an end beat from the next start beat. If valid falls in cycle D, the earliest acknowledge of the next frame is cycle D+IPG. With a back-to-back client and no pause this gives exactly IPG idle cycles.
- R8: `tx_err` is high on the end beat when `cl_underrun` is high in the cycle `cl_valid` falls. Otherwise `tx_err` is low.
- R9: `cl_underrun` in any cycle other than the one in which `cl_valid` falls during a frame has no effect on `tx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_valid | input | 1 | Client data valid; a low cycle ends a frame |
| cl_data | input | 8 | Client byte |
| cl_underrun | input | 1 | Client marks the frame end as abnormal |
| pause_req | input | 1 | Holds off new acknowledges while high |
| cl_ack | output | 1 | One-cycle acknowledge of a frame's first byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_err | output | 1 | Frame ended with an underrun |

## Verification
The acknowledge is combinational, so the bench samples it 1 ns after driving the inputs in the same cycle. It compares the cycle against max(rise, D+IPG, end of pause) computed from its own record of when valid fell. Every accepted byte is logged with its accept cycle. The monitor expects the byte, with its markers and error flag, exactly two cycles later, and reports any beat that appears at any other time. Gap width is measured on the output as the count of idle cycles between an end beat and the next start beat.

// File: rtl/tx_hs_pkg.sv
package tx_hs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              err;
    } tx_beat_t;

    localparam tx_beat_t BEAT_NONE = '0;

    function automatic tx_beat_t make_beat(logic [BYTE_W-1:0] d, logic s, logic e, logic x);
        tx_beat_t b;
        b.data = d;
        b.sof  = s;
        b.eof  = e;
        b.err  = x;
        return b;
    endfunction

endpackage

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
    parameter int IPG = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic ready
);
    localparam int CNT_W = $clog2(IPG + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CNT_W'(IPG - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = (cnt_q == '0);

    generate
        if (IPG > 1) begin : g_hold_chk
            // R7
            gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
                restart |=> !ready);
        end
    endgenerate

endmodule

// File: rtl/tx_beat_framer.sv
module tx_beat_framer
    import tx_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              close,
    input  logic              first,
    input  logic              underrun,
    input  logic [BYTE_W-1:0] din,
    output tx_beat_t          beat_o,
    output logic              valid_o
);
    logic [BYTE_W-1:0] hold_q;
    logic              hold_first_q;
    logic              hold_vld_q;
    tx_beat_t          beat_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q       <= '0;
            hold_first_q <= 1'b0;
            hold_vld_q   <= 1'b0;
            beat_q       <= BEAT_NONE;
            valid_q      <= 1'b0;
        end else begin
            if (hold_vld_q && (take || close)) begin
                beat_q  <= make_beat(hold_q, hold_first_q, close, close && underrun);
                valid_q <= 1'b1;
            end else begin
                beat_q  <= BEAT_NONE;
                valid_q <= 1'b0;
            end
            if (take) begin
                hold_q       <= din;
                hold_first_q <= first;
                hold_vld_q   <= 1'b1;
            end else if (close) begin
                hold_vld_q   <= 1'b0;
            end
        end
    end

    assign beat_o  = beat_q;
    assign valid_o = valid_q;

    // R6
    frame_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !beat_q.eof) |=> valid_q);

endmodule

// File: rtl/tx_client_acceptor.sv
module tx_client_acceptor
    import tx_hs_pkg::*;
#(
    parameter int IPG = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cl_valid,
    input  logic [BYTE_W-1:0] cl_data,
    input  logic              cl_underrun,
    input  logic              pause_req,
    output logic              cl_ack,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_err
);
    localparam int RUN_W = $clog2(IPG + 2) + 1;

    acc_state_e state_q;
    logic       gap_ready;
    logic       accept_first;
    logic       take;
    logic       close;
    tx_beat_t   beat;

    assign accept_first = (state_q == ST_IDLE) && cl_valid && gap_ready && !pause_req;
    assign take         = accept_first || ((state_q == ST_SEND) && cl_valid);
    assign close        = (state_q == ST_SEND) && !cl_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (accept_first) begin
            state_q <= ST_SEND;
        end else if (close) begin
            state_q <= ST_IDLE;
        end
    end

    tx_gap_timer #(.IPG(IPG)) i_gap (
        .clk     (clk),
        .rst     (rst),
        .restart (close),
        .ready   (gap_ready)
    );

    tx_beat_framer i_framer (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .close    (close),
        .first    (accept_first),
        .underrun (cl_underrun),
        .din      (cl_data),
        .beat_o   (beat),
        .valid_o  (tx_valid)
    );

    assign cl_ack  = accept_first;
    assign tx_data = beat.data;
    assign tx_sof  = beat.sof;
    assign tx_eof  = beat.eof;
    assign tx_err  = beat.err;

    // idle-run tracker on the output, used only by the gap assertion
    logic [RUN_W-1:0] idle_run_q;
    logic             seen_eof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run_q <= '0;
            seen_eof_q <= 1'b0;
        end else if (tx_valid && tx_eof) begin
            idle_run_q <= '0;
            seen_eof_q <= 1'b1;
        end else if (!tx_valid && idle_run_q < RUN_W'(IPG)) begin
            idle_run_q <= idle_run_q + 1'b1;
        end
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cl_ack |=> !cl_ack);

    // R3
    pause_block_chk: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> !cl_ack);

    // R5
    sof_latency_chk: assert property (@(posedge clk) disable iff (rst)
        cl_ack |=> ##1 (tx_valid && tx_sof));

    // R7
    gap_width_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sof && seen_eof_q) |-> (idle_run_q >= RUN_W'(IPG)));

    // R8
    underrun_err_chk: assert property (@(posedge clk) disable iff (rst)
        (close && cl_underrun) |=> (tx_valid && tx_eof && tx_err));

endmodule

// File: tb/test_tx_client_acceptor.sv
`timescale 1ns/1ps
module test_tx_client_acceptor;

    localparam int IPG = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cl_valid = 1'b0;
    logic [7:0] cl_data = 8'h00;
    logic       cl_underrun = 1'b0;
    logic       pause_req = 1'b0;
    logic       cl_ack;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_sof;
    logic       tx_eof;
    logic       tx_err;

    always #2.5 clk = ~clk;

    tx_client_acceptor #(.IPG(IPG)) i_tx_client_acceptor (
        .clk(clk), .rst(rst), .cl_valid(cl_valid), .cl_data(cl_data),
        .cl_underrun(cl_underrun), .pause_req(pause_req), .cl_ack(cl_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_err(tx_err)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    bit mon_en = 0;

    int   exp_cyc  [0:1023];
    logic [7:0] exp_data [0:1023];
    bit   exp_sof  [0:1023];
    bit   exp_eof  [0:1023];
    bit   exp_err  [0:1023];
    int   wr = 0;
    int   rd = 0;
    int   last_fall = -1000;
    int   last_eof_cyc = 0;
    bit   seen_eof = 0;
    bit   first_frame = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit s);
        exp_cyc[wr]  = cyc + 2;
        exp_data[wr] = d;
        exp_sof[wr]  = s;
        exp_eof[wr]  = 0;
        exp_err[wr]  = 0;
        wr++;
    endtask

    // output monitor: every beat due at its accept cycle + 2
    always @(negedge clk) begin
        if (mon_en) begin
            if (rd < wr && exp_cyc[rd] == cyc) begin
                chk(tx_valid, "R5", "beat valid", int'(tx_valid), 1);
                chk(tx_data == exp_data[rd], "R5", "beat data", int'(tx_data), int'(exp_data[rd]));
                chk(tx_sof == exp_sof[rd], "R6", "sof marker", int'(tx_sof), int'(exp_sof[rd]));
                chk(tx_eof == exp_eof[rd], "R6", "eof marker", int'(tx_eof), int'(exp_eof[rd]));
                chk(tx_err == exp_err[rd], exp_err[rd] ? "R8" : "R9", "err flag",
                    int'(tx_err), int'(exp_err[rd]));
                if (tx_valid && tx_sof && seen_eof)
                    chk(cyc - last_eof_cyc - 1 >= IPG, "R7", "idle gap",
                        cyc - last_eof_cyc - 1, IPG);
                if (tx_valid && tx_eof) begin
                    last_eof_cyc = cyc;
                    seen_eof = 1;
                end
                rd++;
            end else if (tx_valid) begin
                chk(0, "R4", "unexpected beat", int'(tx_data), -1);
            end
        end
    end

    task automatic send_frame(input int len, input int base, input bit urun,
                              input int idle_before, input int pause_len,
                              input bit mid_noise);
        int rise;
        int exp_ack;
        for (int i = 0; i < idle_before; i++) begin
            @(negedge clk);
            cl_valid = 0;
            cl_underrun = 0;
            cl_data = 8'h5A;
        end
        @(negedge clk);
        cl_valid = 1;
        cl_data = 8'(base);
        cl_underrun = 0;
        rise = cyc;
        pause_req = (pause_len > 0);
        #1;
        while (!cl_ack) begin
            @(negedge clk);
            pause_req = ((cyc - rise) < pause_len);
            #1;
        end
        exp_ack = rise;
        if (last_fall + IPG > exp_ack) exp_ack = last_fall + IPG;
        if (rise + pause_len > exp_ack) exp_ack = rise + pause_len;
        chk(cyc == exp_ack, first_frame ? "R1" : (pause_len > 0 ? "R3" : "R7"),
            "ack cycle", cyc - rise, exp_ack - rise);
        first_frame = 0;
        push(8'(base), 1);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            cl_data = 8'(base + i);
            pause_req = mid_noise;
            cl_underrun = mid_noise;
            #1;
            chk(!cl_ack, "R2", "second ack in frame", int'(cl_ack), 0);
            push(8'(base + i), 0);
        end
        @(negedge clk);
        cl_valid = 0;
        cl_underrun = urun;
        cl_data = 8'hEE;
        pause_req = 0;
        last_fall = cyc;
        exp_eof[wr-1] = 1;
        exp_err[wr-1] = urun;
        #1;
        chk(!cl_ack, "R2", "ack at frame end", int'(cl_ack), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk(!cl_ack, "R1", "ack after reset", int'(cl_ack), 0);
        chk(!tx_valid, "R1", "valid after reset", int'(tx_valid), 0);
        chk(!tx_sof && !tx_eof && !tx_err, "R1", "markers after reset",
            int'({tx_sof, tx_eof, tx_err}), 0);
        mon_en = 1;

        // sweep: length x idle-before x underrun-at-end
        for (int len = 1; len <= 5; len++) begin
            for (int gi = 0; gi < 3; gi++) begin
                for (int u = 0; u < 2; u++) begin
                    int g;
                    g = (gi == 0) ? 0 : ((gi == 1) ? 3 : 15);
                    send_frame(len, len * 40 + g * 2 + u, bit'(u), g, 0, gi == 1);
                end
            end
        end

        // pause cases (R3)
        send_frame(3, 8'hA0, 0, 0, 20, 0);  // pause outlasts gap
        send_frame(2, 8'hB0, 0, 0, 4, 0);   // gap outlasts pause
        send_frame(4, 8'hC0, 1, 20, 5, 1);  // gap long done, pause decides
        send_frame(1, 8'hD0, 0, 0, 0, 0);   // back-to-back single byte

        @(negedge clk);
        cl_valid = 0;
        cl_underrun = 0;
        repeat (6) @(negedge clk);
        chk(rd == wr, "R5", "beats delivered", rd, wr);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule